// File: doc/BRIEF.md
# Interrupt Pin Level Tracker and Delivery Engine

This block sits between a set of interrupt pins and the message fabric that reaches the processors' local interrupt controllers. Each pin keeps a signed count of asserts minus deasserts. A pin asks for delivery only when its count steps from zero to one. A pin can also be re-armed when its routing entry is rewritten, or when an end-of-interrupt (EOI) arrives for its vector. For level-triggered pins the block keeps a remote-IRR bit. That bit is set when a delivery is accepted, and a later delivery through rewrite or EOI must wait until it is clear.

Each pin's routing entry is a packed 22-bit field on an input bus and is owned by the surrounding register logic. Pins that have been accepted for delivery wait in a pending set. They are offered one at a time, lowest pin first, on a valid/ready message port. An EOI is handled by a serial scan that looks at one pin per clock. While the scan runs, a busy output holds off further EOIs.

Top module: `irq_route_engine`

## Requirements
- R1: During reset and on the first cycle after it, all counters are zero, no message is offered, every remote-IRR bit is clear, no error bit is set and busy is low.
- R2: An assert adds one to the pin's counter and a deassert subtracts one. A pulse acts as an assert followed at once by a deassert. Requests in the same cycle take effect in the order assert, pulse, deassert.
- R3: A delivery attempt is caused by any step that moves the counter from 0 to 1, whatever the state of remote IRR. No other counter change causes one.
- R4: The pin's error output is high exactly while its counter is below zero.
- R5: An attempt on a pin whose entry has the mask bit (bit 13) set is dropped. It leaves no pending message and no change to remote IRR.
- R6: An accepted attempt on a pin whose entry is level-triggered (bit 12 set) sets that pin's remote IRR.
- R7: The offered message carries the pin index, the vector (entry bits 7:0), the delivery mode (bits 10:8), logical destination mode (bit 11), trigger mode (bit 12) and destination (bits 21:14). The fields are read from the entry at the time the message is offered.
- R8: An accepted EOI starts a scan in which pin k is examined k+1 cycles after acceptance. If the pin's remote IRR is set and its vector equals the EOI vector, remote IRR is cleared. If the pin's counter is positive at that point, a new attempt is made.
- R9: Busy stays high for exactly NUM_PINS cycles after an EOI is accepted. An EOI presented while busy is ignored.
- R10: A rewrite notice for a pin causes an attempt when the entry is unmasked, the pin's remote IRR is clear and its counter is positive.
- R11: Pending pins are offered lowest index first, one per valid-and-ready handshake. The offer stays up until it is accepted. Further attempts on a pin that is already pending merge into the one message.
- R12: A pin accepted at a clock edge is offered from that same edge. Each condition is judged on the state held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_assert | input | NUM_PINS | Per-pin assert request |
| pin_deassert | input | NUM_PINS | Per-pin deassert request |
| pin_pulse | input | NUM_PINS | Per-pin pulse request |
| entry_i | input | NUM_PINS*22 | Packed routing entries, pin p at bits p*22 and up |
| rewrite_valid | input | 1 | An entry has just been rewritten |
| rewrite_pin | input | IDX_W | Index of the rewritten entry |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| eoi_busy | output | 1 | EOI scan in progress |
| msg_valid | output | 1 | A delivery message is offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_pin | output | IDX_W | Pin the message belongs to |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Logical destination mode |
| msg_level | output | 1 | Level-triggered message |
| rirr_o | output | NUM_PINS | Remote-IRR bit per pin |
| cnt_err_o | output | NUM_PINS | Counter below zero per pin |

## Verification
The hardest case to reach is re-delivery on EOI. A level-triggered pin has to be accepted, its counter held above zero, and then a matching EOI issued. The check must then land on the one clock when the scan reaches that pin. The directed sequence counts the scan slots from the acceptance edge and checks that remote IRR is cleared and set again in the same cycle, with a fresh message. It then repeats the EOI with the counter back at zero to show that no message follows. A long random phase draws vectors from only four values, so matching EOIs, blocked rewrites and merged attempts occur often. A behavioural model is compared with the block on every clock.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ENTRY_W     = 22;
  localparam int VEC_W       = 8;
  localparam int VEC_LSB     = 0;
  localparam int DMODE_LSB   = 8;
  localparam int DMODE_W     = 3;
  localparam int LOGICAL_BIT = 11;
  localparam int LEVEL_BIT   = 12;
  localparam int MASK_BIT    = 13;
  localparam int DEST_LSB    = 14;
  localparam int DEST_W      = 8;

  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic               level;
    logic               logical;
    logic [DMODE_W-1:0] dmode;
    logic [VEC_W-1:0]   vec;
  } route_t;

  function automatic route_t route_of(input logic [ENTRY_W-1:0] e);
    route_t r;
    r.vec     = e[VEC_LSB +: VEC_W];
    r.dmode   = e[DMODE_LSB +: DMODE_W];
    r.logical = e[LOGICAL_BIT];
    r.level   = e[LEVEL_BIT];
    r.dest    = e[DEST_LSB +: DEST_W];
    return r;
  endfunction
endpackage

// File: rtl/irq_level_tracker.sv
module irq_level_tracker #(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_assert,
  input  logic [NUM_PINS-1:0] pin_deassert,
  input  logic [NUM_PINS-1:0] pin_pulse,
  output logic [NUM_PINS-1:0] fire,
  output logic [NUM_PINS-1:0] cnt_pos,
  output logic [NUM_PINS-1:0] cnt_neg
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] after_up;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_en;

    // order inside a cycle: assert, then pulse (net zero), then deassert
    assign after_up = cnt_q + {{(CNT_W-1){1'b0}}, pin_assert[g]};
    assign cnt_d    = after_up - {{(CNT_W-1){1'b0}}, pin_deassert[g]};
    assign cnt_en   = pin_assert[g] | pin_deassert[g];

    assign fire[g]    = (pin_assert[g] && (cnt_q == ZERO)) ||
                        (pin_pulse[g]  && (after_up == ZERO));
    assign cnt_neg[g] = cnt_q[CNT_W-1];
    assign cnt_pos[g] = !cnt_q[CNT_W-1] && (cnt_q != ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_eoi_scanner.sv
module irq_eoi_scanner #(
  parameter int NUM_PINS = 32,
  parameter int VEC_W    = 8,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic [NUM_PINS*VEC_W-1:0] pin_vec,
  input  logic [NUM_PINS-1:0]       rirr,
  output logic                      busy,
  output logic [NUM_PINS-1:0]       hit
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PINS - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             start;
  logic             scan_en;

  assign start   = eoi_valid && !active_q;
  assign scan_en = start || active_q;
  assign busy    = active_q;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    vec_d    = vec_q;
    if (active_q) begin
      if (idx_q == LAST) active_d = 1'b0;
      else               idx_d    = idx_q + 1'b1;
    end else if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
      vec_d    = eoi_vector;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      vec_q    <= '0;
    end else if (scan_en) begin
      active_q <= active_d;
      idx_q    <= idx_d;
      vec_q    <= vec_d;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
    assign hit[g] = active_q && (idx_q == IDX_W'(g)) && rirr[g] &&
                    (pin_vec[g*VEC_W +: VEC_W] == vec_q);
  end
endmodule

// File: rtl/irq_dispatch_queue.sv
module irq_dispatch_queue #(
  parameter int NUM_PINS = 32,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_req,
  input  logic                msg_ready,
  output logic                msg_valid,
  output logic [IDX_W-1:0]    grant_idx
);
  logic [NUM_PINS-1:0] pend_q, pend_d;
  logic [NUM_PINS-1:0] lowest;
  logic [NUM_PINS-1:0] clr;
  logic                take;
  logic                pend_en;

  assign lowest    = pend_q & (~pend_q + 1'b1);
  assign msg_valid = |pend_q;
  assign take      = msg_valid && msg_ready;
  assign clr       = take ? lowest : '0;
  assign pend_en   = take || (|set_req);

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (lowest[i]) grant_idx = grant_idx | IDX_W'(i);
    end
  end

  // a new acceptance on the pin being taken keeps it pending
  always_comb pend_d = (pend_q & ~clr) | set_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pin_assert,
  input  logic [NUM_PINS-1:0]         pin_deassert,
  input  logic [NUM_PINS-1:0]         pin_pulse,
  input  logic [NUM_PINS*ENTRY_W-1:0] entry_i,
  input  logic                        rewrite_valid,
  input  logic [IDX_W-1:0]            rewrite_pin,
  input  logic                        eoi_valid,
  input  logic [VEC_W-1:0]            eoi_vector,
  output logic                        eoi_busy,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [IDX_W-1:0]            msg_pin,
  output logic [VEC_W-1:0]            msg_vector,
  output logic [DEST_W-1:0]           msg_dest,
  output logic [DMODE_W-1:0]          msg_dmode,
  output logic                        msg_logical,
  output logic                        msg_level,
  output logic [NUM_PINS-1:0]         rirr_o,
  output logic [NUM_PINS-1:0]         cnt_err_o
);
  logic [NUM_PINS-1:0]       fire, cnt_pos, cnt_neg;
  logic [NUM_PINS-1:0]       hit;
  logic [NUM_PINS-1:0]       accept, rirr_set;
  logic [NUM_PINS-1:0]       rirr_q, rirr_d;
  logic                      rirr_en;
  logic [NUM_PINS*VEC_W-1:0] pin_vec;
  logic [IDX_W-1:0]          grant_idx;
  route_t                    routes [NUM_PINS];
  route_t                    sel;

  irq_level_tracker #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .pin_assert(pin_assert), .pin_deassert(pin_deassert), .pin_pulse(pin_pulse),
    .fire(fire), .cnt_pos(cnt_pos), .cnt_neg(cnt_neg)
  );

  irq_eoi_scanner #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .pin_vec(pin_vec), .rirr(rirr_q),
    .busy(eoi_busy), .hit(hit)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_route
    logic masked;
    logic rewrite_arm;
    logic attempt;

    assign routes[g]                  = route_of(entry_i[g*ENTRY_W +: ENTRY_W]);
    assign masked                     = entry_i[g*ENTRY_W + MASK_BIT];
    assign pin_vec[g*VEC_W +: VEC_W]  = routes[g].vec;

    assign rewrite_arm = rewrite_valid && (rewrite_pin == IDX_W'(g)) &&
                         !masked && !rirr_q[g] && cnt_pos[g];
    assign attempt     = fire[g] || (hit[g] && cnt_pos[g]) || rewrite_arm;
    assign accept[g]   = attempt && !masked;
    assign rirr_set[g] = accept[g] && routes[g].level;
  end

  assign rirr_en = (|hit) || (|rirr_set);

  always_comb rirr_d = (rirr_q & ~hit) | rirr_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rirr_q <= '0;
    else if (rirr_en) rirr_q <= rirr_d;
  end

  irq_dispatch_queue #(.NUM_PINS(NUM_PINS)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .set_req(accept), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .grant_idx(grant_idx)
  );

  assign sel         = routes[grant_idx];
  assign msg_pin     = grant_idx;
  assign msg_vector  = sel.vec;
  assign msg_dest    = sel.dest;
  assign msg_dmode   = sel.dmode;
  assign msg_logical = sel.logical;
  assign msg_level   = sel.level;
  assign rirr_o      = rirr_q;
  assign cnt_err_o   = cnt_neg;
endmodule

// File: rtl/irq_route_engine_chk.sv
module irq_route_engine_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_deassert,
  input logic                eoi_valid,
  input logic                eoi_busy,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [NUM_PINS-1:0] rirr_o,
  input logic [NUM_PINS-1:0] cnt_err_o
);
  logic [15:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_run <= '0;
    else if (eoi_busy) busy_run <= busy_run + 1'b1;
    else               busy_run <= '0;
  end

  p_offer_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid);

  p_scan_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && !eoi_busy |=> eoi_busy);

  p_scan_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_busy && (busy_run == 16'(NUM_PINS - 1)) |=> !eoi_busy);

  p_scan_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_busy && (busy_run < 16'(NUM_PINS - 1)) |=> eoi_busy);

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_err_o & ~$past(cnt_err_o) & ~$past(pin_deassert)) == '0);

  p_rirr_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    |(rirr_o & ~$past(rirr_o)) |-> msg_valid);
endmodule

bind irq_route_engine irq_route_engine_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_deassert(pin_deassert),
  .eoi_valid(eoi_valid), .eoi_busy(eoi_busy),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .rirr_o(rirr_o), .cnt_err_o(cnt_err_o)
);

// File: tb/irq_route_engine_test.sv
`timescale 1ns/1ps
module irq_route_engine_test;
  localparam int NP = 32;
  localparam int IW = 5;
  localparam int EW = 22;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP-1:0]   pin_assert, pin_deassert, pin_pulse;
  logic [NP*EW-1:0] entry_i;
  logic            rewrite_valid;
  logic [IW-1:0]   rewrite_pin;
  logic            eoi_valid;
  logic [7:0]      eoi_vector;
  logic            eoi_busy, msg_valid, msg_ready;
  logic [IW-1:0]   msg_pin;
  logic [7:0]      msg_vector, msg_dest;
  logic [2:0]      msg_dmode;
  logic            msg_logical, msg_level;
  logic [NP-1:0]   rirr_o, cnt_err_o;
  logic [EW-1:0]   ent [NP];

  int total = 0;
  int bad = 0;

  // behavioural model state
  int  m_cnt [NP];
  bit  m_rirr [NP];
  bit  m_pend [NP];
  bit  m_busy;
  int  m_idx;
  logic [7:0] m_vec;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NP; g++) begin : g_ent
    assign entry_i[g*EW +: EW] = ent[g];
  end

  irq_route_engine uut (
    .clk(clk), .rst_n(rst_n),
    .pin_assert(pin_assert), .pin_deassert(pin_deassert), .pin_pulse(pin_pulse),
    .entry_i(entry_i), .rewrite_valid(rewrite_valid), .rewrite_pin(rewrite_pin),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_busy(eoi_busy),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dmode(msg_dmode),
    .msg_logical(msg_logical), .msg_level(msg_level),
    .rirr_o(rirr_o), .cnt_err_o(cnt_err_o)
  );

  // entry layout: vec[7:0] dmode[10:8] logical[11] level[12] mask[13] dest[21:14]
  function automatic logic [EW-1:0] mk(input logic [7:0] vec, input logic [2:0] dm,
                                        input logic lg, input logic lv,
                                        input logic mk_bit, input logic [7:0] dest);
    return {dest, mk_bit, lv, lg, dm, vec};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest_pend();
    for (int p = 0; p < NP; p++) if (m_pend[p]) return p;
    return -1;
  endfunction

  // model step at each rising edge, comparison shortly after
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_cnt[p] = 0; m_rirr[p] = 0; m_pend[p] = 0;
      end
      m_busy = 0; m_idx = 0; m_vec = '0;
    end else begin
      int  lp;
      int  n_cnt [NP];
      bit  n_rirr [NP];
      bit  n_pend [NP];
      lp = lowest_pend();
      for (int p = 0; p < NP; p++) begin
        int c0, c1;
        bit fire, hit, rw, acc;
        c0 = m_cnt[p];
        c1 = c0 + int'(pin_assert[p]);
        fire = (pin_assert[p] && c0 == 0) || (pin_pulse[p] && c1 == 0);
        hit  = m_busy && m_idx == p && m_rirr[p] && ent[p][7:0] == m_vec;
        rw   = rewrite_valid && int'(rewrite_pin) == p && !ent[p][13] &&
               !m_rirr[p] && c0 > 0;
        acc  = (fire || (hit && c0 > 0) || rw) && !ent[p][13];
        n_cnt[p]  = c1 - int'(pin_deassert[p]);
        n_rirr[p] = (m_rirr[p] && !hit) || (acc && ent[p][12]);
        n_pend[p] = (m_pend[p] && !(msg_ready && lp == p)) || acc;
      end
      for (int p = 0; p < NP; p++) begin
        m_cnt[p] = n_cnt[p]; m_rirr[p] = n_rirr[p]; m_pend[p] = n_pend[p];
      end
      if (m_busy) begin
        if (m_idx == NP - 1) m_busy = 0;
        else m_idx++;
      end else if (eoi_valid) begin
        m_busy = 1; m_idx = 0; m_vec = eoi_vector;
      end
    end
    #1;
    if (rst_n) begin
      int lp2;
      logic [NP-1:0] er, ee;
      lp2 = lowest_pend();
      chk(msg_valid == (lp2 >= 0), "R11 model offer", msg_valid, lp2 >= 0);
      if (lp2 >= 0 && msg_valid) begin
        chk(int'(msg_pin) == lp2, "R11 model order", msg_pin, lp2);
        chk(msg_vector == ent[lp2][7:0], "R7 model vector", msg_vector, ent[lp2][7:0]);
        chk(msg_dmode == ent[lp2][10:8], "R7 model dmode", msg_dmode, ent[lp2][10:8]);
        chk(msg_logical == ent[lp2][11], "R7 model logical", msg_logical, ent[lp2][11]);
        chk(msg_level == ent[lp2][12], "R7 model level", msg_level, ent[lp2][12]);
        chk(msg_dest == ent[lp2][21:14], "R7 model dest", msg_dest, ent[lp2][21:14]);
      end
      for (int p = 0; p < NP; p++) begin
        er[p] = m_rirr[p];
        ee[p] = m_cnt[p] < 0;
      end
      chk(rirr_o == er, "R6 R8 model rirr", rirr_o, er);
      chk(cnt_err_o == ee, "R4 model error", cnt_err_o, ee);
      chk(eoi_busy == m_busy, "R9 model busy", eoi_busy, m_busy);
    end
  end

  task automatic go();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    pin_assert = '0; pin_deassert = '0; pin_pulse = '0;
    rewrite_valid = 1'b0; eoi_valid = 1'b0;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int n;
    rst_n = 1'b0;
    quiet();
    rewrite_pin = '0; eoi_vector = '0; msg_ready = 1'b0;
    for (int p = 0; p < NP; p++) ent[p] = mk(8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    go();
    // R1 reset state
    chk(!msg_valid, "R1 no offer", msg_valid, 0);
    chk(rirr_o == '0, "R1 rirr clear", rirr_o, 0);
    chk(cnt_err_o == '0, "R1 no error", cnt_err_o, 0);
    chk(!eoi_busy, "R1 not busy", eoi_busy, 0);

    // first assert on an edge pin, receiver stalled
    @(negedge clk);
    ent[3] = mk(8'h33, 3'd5, 1'b1, 1'b0, 1'b0, 8'hA5);
    pin_assert[3] = 1'b1;
    go();
    chk(msg_valid, "R12 offer after edge", msg_valid, 1);
    chk(msg_pin == 3, "R3 pin 3 fires", msg_pin, 3);
    chk(msg_vector == 8'h33, "R7 vector", msg_vector, 8'h33);
    chk(msg_dest == 8'hA5, "R7 dest", msg_dest, 8'hA5);
    chk(msg_dmode == 3'd5 && msg_logical && !msg_level, "R7 modes",
        {msg_dmode, msg_logical, msg_level}, {3'd5, 1'b1, 1'b0});
    @(negedge clk); quiet();
    go();
    chk(msg_valid, "R11 offer held", msg_valid, 1);
    @(negedge clk); msg_ready = 1'b1;
    go();
    chk(!msg_valid, "R11 taken", msg_valid, 0);

    // counter 1 -> 2: no delivery
    @(negedge clk); pin_assert[3] = 1'b1;
    go();
    chk(!msg_valid, "R3 no fire 1 to 2", msg_valid, 0);
    @(negedge clk); quiet(); pin_deassert[3] = 1'b1;
    go(); go(); go();
    chk(cnt_err_o[3], "R4 below zero", cnt_err_o[3], 1);
    @(negedge clk); quiet(); pin_assert[3] = 1'b1;
    go();
    chk(!msg_valid && !cnt_err_o[3], "R2 R3 minus one to zero",
        {msg_valid, cnt_err_o[3]}, 0);
    go();
    chk(msg_valid && msg_pin == 3, "R3 zero to one", msg_valid, 1);
    @(negedge clk); quiet(); pin_deassert[3] = 1'b1;
    go();

    // pulse from zero fires and returns to zero
    @(negedge clk); quiet(); pin_pulse[3] = 1'b1;
    go();
    chk(msg_valid, "R2 pulse fires", msg_valid, 1);
    @(negedge clk); quiet(); pin_assert[3] = 1'b1;
    go();
    chk(msg_valid, "R2 pulse left zero", msg_valid, 1);
    // counter now 1: a pulse alone must not fire
    @(negedge clk); quiet(); pin_pulse[3] = 1'b1;
    go();
    go();
    chk(!msg_valid, "R2 pulse at one", msg_valid, 0);
    @(negedge clk); quiet(); pin_deassert[3] = 1'b1;
    go();
    // assert plus pulse together from zero: one message, count one
    @(negedge clk); quiet(); pin_assert[3] = 1'b1; pin_pulse[3] = 1'b1;
    go();
    chk(msg_valid, "R2 assert then pulse", msg_valid, 1);
    @(negedge clk); quiet(); pin_deassert[3] = 1'b1;
    go();
    chk(!cnt_err_o[3], "R2 count was one", cnt_err_o[3], 0);
    @(negedge clk); quiet();

    // masked level pin
    ent[5] = mk(8'h55, 3'd1, 1'b0, 1'b1, 1'b1, 8'h01);
    pin_assert[5] = 1'b1;
    go();
    chk(!msg_valid && !rirr_o[5], "R5 masked dropped", {msg_valid, rirr_o[5]}, 0);
    @(negedge clk); quiet();
    ent[5] = mk(8'h55, 3'd1, 1'b0, 1'b1, 1'b0, 8'h01);
    rewrite_valid = 1'b1; rewrite_pin = 5'd5;
    go();
    chk(msg_valid && msg_pin == 5, "R10 rewrite delivers", msg_pin, 5);
    chk(rirr_o[5], "R6 level sets rirr", rirr_o[5], 1);
    @(negedge clk);
    go();
    chk(!msg_valid, "R10 blocked by rirr", msg_valid, 0);
    @(negedge clk); quiet();
    eoi_valid = 1'b1; eoi_vector = 8'h55;
    go();
    chk(eoi_busy, "R8 scan started", eoi_busy, 1);
    @(negedge clk); quiet();
    repeat (6) go();
    chk(msg_valid && msg_pin == 5 && rirr_o[5], "R8 re-delivery", {msg_valid, rirr_o[5]}, 3);
    @(negedge clk); pin_deassert[5] = 1'b1;
    go();
    @(negedge clk); quiet();
    while (eoi_busy) go();
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h55;
    go();
    @(negedge clk); quiet();
    repeat (6) go();
    chk(!rirr_o[5] && !msg_valid, "R8 clear without delivery", {rirr_o[5], msg_valid}, 0);
    while (eoi_busy) go();

    // busy length with EOI held during the scan
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h77;
    go();
    n = eoi_busy ? 1 : 0;
    while (eoi_busy) begin
      @(negedge clk); eoi_valid = (n < 4);
      go();
      if (eoi_busy) n++;
    end
    chk(n == NP, "R9 busy length", n, NP);
    @(negedge clk); quiet();

    // several pins at once, lowest first
    msg_ready = 1'b0;
    ent[1]  = mk(8'h11, 3'd0, 1'b0, 1'b0, 1'b0, 8'h10);
    ent[9]  = mk(8'h19, 3'd2, 1'b0, 1'b0, 1'b0, 8'h20);
    ent[20] = mk(8'h20, 3'd3, 1'b1, 1'b0, 1'b0, 8'h30);
    pin_assert[1] = 1'b1; pin_assert[9] = 1'b1; pin_assert[20] = 1'b1;
    go();
    chk(msg_pin == 1, "R11 first pin 1", msg_pin, 1);
    @(negedge clk); quiet(); msg_ready = 1'b1;
    go();
    chk(msg_pin == 9, "R11 then pin 9", msg_pin, 9);
    go();
    chk(msg_pin == 20 && msg_vector == 8'h20, "R11 then pin 20", msg_pin, 20);
    go();
    chk(!msg_valid, "R11 drained", msg_valid, 0);

    // random phase against the model
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      ent[p] = mk(8'h40 + 8'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 3) == 0, 8'($urandom_range(0, 255)));
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      quiet();
      for (int p = 0; p < NP; p++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 4 && m_cnt[p] < 4) pin_assert[p] = 1'b1;
        else if (r < 8 && m_cnt[p] > -2) pin_deassert[p] = 1'b1;
        else if (r < 10) pin_pulse[p] = 1'b1;
        else if (r < 12 && m_cnt[p] < 4 && m_cnt[p] > -2) begin
          pin_assert[p] = 1'b1; pin_deassert[p] = 1'b1; pin_pulse[p] = r[0];
        end
      end
      eoi_valid  = $urandom_range(0, 9) == 0;
      eoi_vector = 8'h40 + 8'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) begin
        int q;
        q = $urandom_range(0, NP - 1);
        ent[q] = mk(8'h40 + 8'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    $urandom_range(0, 3) == 0, 8'($urandom_range(0, 255)));
        rewrite_valid = 1'b1;
        rewrite_pin   = IW'(q);
      end
      msg_ready = $urandom_range(0, 3) != 0;
    end
    @(negedge clk); quiet();
    go();
    finish_up();
  end
endmodule